// File: doc/BRIEF.md
# Hardware Monitor Interrupt Collector

This block gathers the out-of-limit flags that a hardware monitor's limit comparators produce and turns them into a single active-low interrupt line. Each monitoring cycle ends with an update strobe. On that strobe the per-channel flags are OR-ed into sticky status registers, which are split into banks of eight bits. A read of a status bank returns its contents and empties it. The bank then stays empty until a later update strobe sets bits again.

Two sets of registers sit between the status bits and the interrupt pin. Per-bit mask registers use the same bit order as the status banks. A configuration register holds an enable and a separate clear. The clear forces the pin inactive but does not touch the status contents.

Five general-purpose input pins can be switched into external interrupt mode. In that mode each pin is a level request with its own polarity and enable. The requests are not stored anywhere: the interrupt follows the pin level. Software reaches everything through a synchronous 8-bit address/data port with read and write strobes. Read data appears on the clock edge after the read strobe.

Top module: `hwmon_irq_ctrl`

## Requirements
- R1: After reset the interrupt output `int_n` is 1, `reg_rdata` is 0, and every register reads 0: CFG1 at 0x40, CHMODE at 0x47, CFG2 at 0x4A, masks at 0x50+b and status at 0x60+b for bank b.
- R2: Status bits are sticky, and when `upd_stb` is 1 the vector `oor_flags` is OR-ed into them. Bank b holds `oor_flags[8b+7:8b]`, with bit i of the bank taken from flag 8b+i. While `upd_stb` is 0, `oor_flags` has no effect.
- R3: A read of status bank b (address 0x60+b) returns the bank's contents on `reg_rdata` one cycle later and clears the bank. A second read, with no update strobe between the two, returns 0.
- R4: When a status read and an update strobe fall in the same cycle, the read returns the old contents and the bank then holds exactly the new flags.
- R5: Mask bank b (address 0x50+b) has the same bit order as status bank b. A mask bit at 1 keeps its status bit from reaching `int_n`.
- R6: `int_n` is 0 in the cycle after any unmasked status bit is 1, provided CFG1 bit 1 (enable) is 1 and CFG1 bit 3 (clear) is 0. When the enable is 0, `int_n` is 1.
- R7: When CFG1 bit 3 is 1, `int_n` is 1 one cycle later. The contents of the status banks do not change.
- R8: When CHMODE bit 7 is 1, the `gp_in` pins act as level requests. The enables for pins 0..2 are CHMODE bits 4..6, and the enables for pins 3..4 are CFG2 bits 6..7. Pins 0..2 are active low and pins 3..4 are active high. An enabled active pin drives `int_n` to 0 one cycle later. The request is not latched, so `int_n` returns to 1 one cycle after the pin goes idle.
- R9: When CHMODE bit 7 is 0, the `gp_in` pins have no effect on `int_n`.
- R10: CFG1, CHMODE, CFG2 and the mask banks are read/write bytes. A write to a status address is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| upd_stb | input | 1 | End-of-monitoring-cycle update strobe |
| oor_flags | input | 16 | Per-channel out-of-limit flags from the comparators |
| gp_in | input | 5 | Voltage-ID pins, usable as level interrupt requests |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| int_n | output | 1 | Active-low interrupt output |

## Verification
The bench builds the block with its default parameters: two status banks of eight bits and five external lines, where the low three lines are active low. With these values every one of the sixteen flag positions, and both polarities of the external requests, can be reached. The vector table pairs a flag pattern with a mask pattern, and it places flags in both banks so that a mismatch in bank alignment shows up on `int_n`. The directed tests cover the read/update collision, the clear bit leaving the status untouched, and the release of an external request that is not latched.

// File: rtl/hwmon_irq_pkg.sv
`timescale 1ns/1ps
package hwmon_irq_pkg;
  localparam int unsigned REG_W = 8;

  // register addresses
  localparam logic [7:0] A_CFG1   = 8'h40;
  localparam logic [7:0] A_CHMODE = 8'h47;
  localparam logic [7:0] A_CFG2   = 8'h4A;
  localparam logic [7:0] A_MASK0  = 8'h50;
  localparam logic [7:0] A_STAT0  = 8'h60;

  // field positions decoded by the interrupt logic
  localparam int unsigned CFG1_EN_BIT  = 1;
  localparam int unsigned CFG1_CLR_BIT = 3;
  localparam int unsigned CHM_MODE_BIT = 7;
  localparam int unsigned CHM_EN_LSB   = 4;
  localparam int unsigned CHM_EN_N     = 3;
  localparam int unsigned CFG2_EN_LSB  = 6;
endpackage

// File: rtl/irq_status_bank.sv
`timescale 1ns/1ps
module irq_status_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] flags,
  input  logic         rd,
  output logic [W-1:0] stat
);
  logic [W-1:0] stat_q, stat_d;
  logic         stat_en;

  // a same-cycle update wins over the read clear, so no event is lost
  always_comb begin
    stat_en = upd | rd;
    stat_d  = stat_q;
    if (upd)     stat_d = (rd ? '0 : stat_q) | flags;
    else if (rd) stat_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign stat = stat_q;

  p_upd_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> ((stat_q & $past(flags)) == $past(flags)));
  p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ((stat_q & ~$past(stat_q)) == '0));
  p_rd_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !upd) |=> (stat_q == '0));
  p_collide_new_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && upd) |=> (stat_q == $past(flags)));
endmodule

// File: rtl/ext_irq_norm.sv
`timescale 1ns/1ps
module ext_irq_norm #(
  parameter int unsigned      N       = 5,
  parameter logic [N-1:0]     ACT_LOW = 5'b00111
) (
  input  logic         mode,
  input  logic [N-1:0] en,
  input  logic [N-1:0] pins,
  output logic [N-1:0] req
);
  // level requests, normalised to active high; nothing is latched here
  for (genvar i = 0; i < N; i++) begin : g_line
    if (ACT_LOW[i]) begin : g_low
      assign req[i] = mode & en[i] & ~pins[i];
    end else begin : g_high
      assign req[i] = mode & en[i] & pins[i];
    end
  end
endmodule

// File: rtl/irq_regfile.sv
`timescale 1ns/1ps
module irq_regfile
  import hwmon_irq_pkg::*;
#(
  parameter int unsigned NB    = 2,
  parameter int unsigned N_EXT = 5,
  localparam int unsigned SW   = NB * REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             wr,
  input  logic             rd,
  input  logic [SW-1:0]    stat,
  output logic [SW-1:0]    mask,
  output logic [NB-1:0]    stat_rd,
  output logic             int_en,
  output logic             int_clr,
  output logic             irq_mode,
  output logic [N_EXT-1:0] ext_en,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] cfg1_q, chm_q, cfg2_q, rdata_q, rd_mux;
  logic [SW-1:0]    mask_q;
  logic             we_cfg1, we_chm, we_cfg2;
  logic [NB-1:0]    we_mask;

  always_comb begin
    we_cfg1 = wr && (addr == A_CFG1);
    we_chm  = wr && (addr == A_CHMODE);
    we_cfg2 = wr && (addr == A_CFG2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg1_q <= '0;
      chm_q  <= '0;
      cfg2_q <= '0;
    end else begin
      if (we_cfg1) cfg1_q <= wdata;
      if (we_chm)  chm_q  <= wdata;
      if (we_cfg2) cfg2_q <= wdata;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign we_mask[b] = wr && (addr == A_MASK0 + 8'(b));
    assign stat_rd[b] = rd && (addr == A_STAT0 + 8'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask_q[b*REG_W +: REG_W] <= '0;
      else if (we_mask[b]) mask_q[b*REG_W +: REG_W] <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == A_CFG1)   rd_mux = cfg1_q;
    if (addr == A_CHMODE) rd_mux = chm_q;
    if (addr == A_CFG2)   rd_mux = cfg2_q;
    for (int b = 0; b < NB; b++) begin
      if (addr == A_MASK0 + 8'(b)) rd_mux = mask_q[b*REG_W +: REG_W];
      if (addr == A_STAT0 + 8'(b)) rd_mux = stat[b*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign rdata    = rdata_q;
  assign mask     = mask_q;
  assign int_en   = cfg1_q[CFG1_EN_BIT];
  assign int_clr  = cfg1_q[CFG1_CLR_BIT];
  assign irq_mode = chm_q[CHM_MODE_BIT];
  assign ext_en   = {cfg2_q[CFG2_EN_LSB +: N_EXT-CHM_EN_N], chm_q[CHM_EN_LSB +: CHM_EN_N]};

  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata_q));
  p_cfg_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we_cfg1 |=> (cfg1_q == $past(wdata)));
endmodule

// File: rtl/hwmon_irq_ctrl.sv
`timescale 1ns/1ps
module hwmon_irq_ctrl
  import hwmon_irq_pkg::*;
#(
  parameter int unsigned  NB          = 2,
  parameter int unsigned  N_EXT       = 5,
  parameter logic [N_EXT-1:0] EXT_ACT_LOW = 5'b00111,
  localparam int unsigned SW          = NB * REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_stb,
  input  logic [SW-1:0]    oor_flags,
  input  logic [N_EXT-1:0] gp_in,
  input  logic [7:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             reg_wr,
  input  logic             reg_rd,
  output logic [REG_W-1:0] reg_rdata,
  output logic             int_n
);
  logic             rst_meta_q, rst_sync_q;
  logic [SW-1:0]    stat, mask;
  logic [NB-1:0]    stat_rd;
  logic             int_en, int_clr, irq_mode;
  logic [N_EXT-1:0] ext_en, ext_req;
  logic             int_n_q, int_n_d, any_stat;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  irq_regfile #(.NB(NB), .N_EXT(N_EXT)) u_regs (
    .clk(clk), .rst_n(rst_sync_q), .addr(reg_addr), .wdata(reg_wdata),
    .wr(reg_wr), .rd(reg_rd), .stat(stat), .mask(mask), .stat_rd(stat_rd),
    .int_en(int_en), .int_clr(int_clr), .irq_mode(irq_mode),
    .ext_en(ext_en), .rdata(reg_rdata)
  );

  for (genvar b = 0; b < NB; b++) begin : g_stat
    irq_status_bank #(.W(REG_W)) u_bank (
      .clk(clk), .rst_n(rst_sync_q), .upd(upd_stb),
      .flags(oor_flags[b*REG_W +: REG_W]), .rd(stat_rd[b]),
      .stat(stat[b*REG_W +: REG_W])
    );
  end

  ext_irq_norm #(.N(N_EXT), .ACT_LOW(EXT_ACT_LOW)) u_ext (
    .mode(irq_mode), .en(ext_en), .pins(gp_in), .req(ext_req)
  );

  always_comb begin
    any_stat = |(stat & ~mask);
    int_n_d  = ~(int_en & ~int_clr & (any_stat | (|ext_req)));
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) int_n_q <= 1'b1;
    else             int_n_q <= int_n_d;
  end

  assign int_n = int_n_q;

  p_disabled_high_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !int_en |=> int_n);
  p_clear_high_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    int_clr |=> int_n);
  p_clear_keeps_stat_r7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (int_clr && !upd_stb && (stat_rd == '0)) |=> $stable(stat));
  p_ext_off_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !irq_mode |-> (ext_req == '0));
endmodule

// File: tb/tb_hwmon_irq_ctrl.sv
`timescale 1ns/1ps
module tb_hwmon_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_stb;
  logic [15:0] oor_flags;
  logic [4:0]  gp_in;
  logic [7:0]  reg_addr, reg_wdata, reg_rdata;
  logic        reg_wr, reg_rd, int_n;

  int n_tests = 0;
  int n_fail  = 0;

  localparam logic [4:0] GP_IDLE = 5'b00111;
  localparam logic [7:0] A_CFG1 = 8'h40, A_CHM = 8'h47, A_CFG2 = 8'h4A,
                         A_M0 = 8'h50, A_M1 = 8'h51, A_S0 = 8'h60, A_S1 = 8'h61;

  // {flags, mask, expected int_n}
  localparam int NV = 7;
  localparam logic [32:0] VEC [NV] = '{
    {16'h0001, 16'h0000, 1'b0},
    {16'h0001, 16'h0001, 1'b1},
    {16'h8000, 16'h7FFF, 1'b0},
    {16'h8000, 16'h8000, 1'b1},
    {16'h0000, 16'h0000, 1'b1},
    {16'h00A5, 16'h00A0, 1'b0},
    {16'h0300, 16'h0100, 1'b0}
  };

  always #10 clk = ~clk;

  hwmon_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .oor_flags(oor_flags),
    .gp_in(gp_in), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .int_n(int_n)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic upd(input logic [15:0] f);
    @(negedge clk); oor_flags = f; upd_stb = 1'b1;
    @(negedge clk); upd_stb = 1'b0; oor_flags = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; upd_stb = 1'b0; oor_flags = '0; gp_in = GP_IDLE;
    reg_addr = '0; reg_wdata = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    chk("R1 int_n", 16'(int_n), 16'h1);
    chk("R1 rdata", 16'(reg_rdata), 16'h0);
    rd(A_CFG1, d); chk("R1 cfg1", 16'(d), 16'h0);
    rd(A_M1, d);   chk("R1 mask1", 16'(d), 16'h0);
    rd(A_S0, d);   chk("R1 stat0", 16'(d), 16'h0);

    // R10 read/write registers, status not writable
    wr(A_CFG2, 8'hC0); rd(A_CFG2, d); chk("R10 cfg2", 16'(d), 16'hC0);
    wr(A_CFG2, 8'h00);
    wr(A_M0, 8'h5A);   rd(A_M0, d);   chk("R10 mask0", 16'(d), 16'h5A);
    wr(A_S0, 8'hFF);   rd(A_S0, d);   chk("R10 stat write ignored", 16'(d), 16'h0);
    wr(A_M0, 8'h00);

    // vector table: R5 masking, R6 output, R2 bank bit order
    wr(A_CFG1, 8'h02);
    for (int i = 0; i < NV; i++) begin
      logic [15:0] f, m;
      f = VEC[i][32:17]; m = VEC[i][16:1];
      wr(A_M0, m[7:0]); wr(A_M1, m[15:8]);
      upd(f); step();
      chk($sformatf("R5/R6 vec%0d int_n", i), 16'(int_n), 16'(VEC[i][0]));
      rd(A_S0, d); chk($sformatf("R2 vec%0d stat0", i), 16'(d), 16'(f[7:0]));
      rd(A_S1, d); chk($sformatf("R2 vec%0d stat1", i), 16'(d), 16'(f[15:8]));
    end
    wr(A_M0, 8'h00); wr(A_M1, 8'h00);

    // R2 sticky accumulation, flags ignored without strobe
    upd(16'h0001); upd(16'h0004);
    @(negedge clk); oor_flags = 16'h00F0; step(); oor_flags = '0;
    rd(A_S0, d); chk("R2 sticky", 16'(d), 16'h05);
    // R3 read clears
    rd(A_S0, d); chk("R3 second read", 16'(d), 16'h00);
    step(); chk("R3 int released", 16'(int_n), 16'h1);

    // R4 read and update in the same cycle
    upd(16'h0001);
    @(negedge clk); reg_addr = A_S0; reg_rd = 1'b1; upd_stb = 1'b1; oor_flags = 16'h0002;
    @(negedge clk); reg_rd = 1'b0; upd_stb = 1'b0; oor_flags = '0; d = reg_rdata;
    chk("R4 old value", 16'(d), 16'h01);
    rd(A_S0, d); chk("R4 new value kept", 16'(d), 16'h02);

    // R6 enable off / R7 clear bit
    upd(16'h0100); step();
    chk("R6 asserted", 16'(int_n), 16'h0);
    wr(A_CFG1, 8'h0A); step();
    chk("R7 clear forces high", 16'(int_n), 16'h1);
    wr(A_CFG1, 8'h02); step();
    chk("R7 status kept", 16'(int_n), 16'h0);
    wr(A_CFG1, 8'h00); step();
    chk("R6 disabled", 16'(int_n), 16'h1);
    rd(A_S1, d); chk("R7 stat1 intact", 16'(d), 16'h01);
    wr(A_CFG1, 8'h02);

    // R9 pins ignored outside interrupt mode
    wr(A_CHM, 8'h70); wr(A_CFG2, 8'hC0);
    @(negedge clk); gp_in = 5'b11000; step();
    chk("R9 mode off", 16'(int_n), 16'h1);
    gp_in = GP_IDLE;

    // R8 external level requests, not latched
    wr(A_CHM, 8'h90); wr(A_CFG2, 8'h80); step();
    chk("R8 idle", 16'(int_n), 16'h1);
    @(negedge clk); gp_in[0] = 1'b0; step();
    chk("R8 irq0 active low", 16'(int_n), 16'h0);
    gp_in[0] = 1'b1; step();
    chk("R8 irq0 unlatched", 16'(int_n), 16'h1);
    gp_in[1] = 1'b0; step();
    chk("R8 irq1 disabled", 16'(int_n), 16'h1);
    gp_in[1] = 1'b1;
    gp_in[3] = 1'b1; step();
    chk("R8 irq3 disabled", 16'(int_n), 16'h1);
    gp_in[3] = 1'b0;
    gp_in[4] = 1'b1; step();
    chk("R8 irq4 active high", 16'(int_n), 16'h0);
    gp_in[4] = 1'b0; step();
    chk("R8 irq4 unlatched", 16'(int_n), 16'h1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule